// File: doc/BRIEF.md
# Low Pin Count I/O Cycle Target

This block sits on the peripheral side of a Low Pin Count bus and answers only I/O read and I/O write cycles. It runs on the bus clock and watches the active-low frame strobe and the 4-bit multiplexed nibble bus. It recognises a cycle start, decodes the cycle type, assembles a 16-bit I/O address over four clocks and compares it against four host-visible register addresses. These are an inbound data register that the host writes and the local processor reads, an outbound data register that the processor writes and the host reads, a status byte, and a mailbox byte that both sides can write. Memory, DMA and bus-master cycles are not answered, and the block never drives the nibble bus for them.

For a matched cycle the target always answers with a ready sync code, so it never inserts wait states. For a read it returns the data byte low nibble first, followed by the 1111 turnaround. All register and flag side effects of a host cycle are applied at the end of the slave turnaround state. A cycle cut short by the host before that point leaves every register and flag as it was.

The local processor side is a plain register port made of write strobes, data inputs and level outputs.

Top module: `lpc_io_slave`

## Requirements
- R1: After reset, lad_oe, busy, in_full and out_full are 0, and in_data and mbox_data are 0x00.
- R2: A cycle starts when lframe_n is sampled low with lad_i = 0000. While lframe_n stays low over several clocks, only the nibble sampled in the last clock with lframe_n low counts as the start code, and any other value means no cycle.
- R3: The nibble after the start selects the cycle type: 0000 is an I/O read and 0010 is an I/O write. Any other value is ignored. The block then never drives lad and changes no register or flag until the next start.
- R4: The address arrives in states 3 to 6 as bits 15:12, 11:8, 7:4 and 3:0. It hits only when all 16 bits equal one of ADDR_IN, ADDR_OUT, ADDR_STAT or ADDR_MBOX. On a miss, lad_oe stays 0 for the whole cycle and nothing changes.
- R5: In a write, data bits 3:0 arrive in state 7 and bits 7:4 in state 8. A hit on ADDR_IN loads in_data and sets in_full at the end of state 12, so the change is visible from state 13. A write to ADDR_OUT or ADDR_STAT changes nothing.
- R6: In a hit read, lad_oe is 1 in states 9 to 12 only. lad_o carries 0000, data bits 3:0, data bits 7:4 and then 1111 in those states. Data comes from in_data, the outbound register, the status byte or the mailbox, sampled at the end of state 6. The status byte is 0 except for bit 1 = in_full and bit 0 = out_full.
- R7: In a hit write, lad_oe is 1 in state 11 with 0000 and in state 12 with 1111, and 0 in every other state, including state 13.
- R8: busy is 1 from state 7 to state 12 of a hit cycle and returns to 0 at the end of state 12.
- R9: lframe_n sampled low in states 3 to 12 ends the cycle at once. lad_oe and busy are 0 from the next clock, and no register or flag changes.
- R10: cpu_out_we loads the outbound register and sets out_full. A completed host read of ADDR_OUT clears out_full, and cpu_out_we in the same clock wins.
- R11: cpu_in_ack clears in_full. A host write commit to ADDR_IN in the same clock wins.
- R12: cpu_mbox_we loads mbox_data, and a completed host write to ADDR_MBOX loads it too. The host write wins if both occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | Nibble bus as sampled |
| lad_o | output | 4 | Nibble driven by the target |
| lad_oe | output | 1 | Target drives the nibble bus |
| cpu_out_data | input | 8 | Byte for the outbound register |
| cpu_out_we | input | 1 | Load the outbound register |
| cpu_in_ack | input | 1 | Processor has taken the inbound byte |
| cpu_mbox_data | input | 8 | Byte for the mailbox |
| cpu_mbox_we | input | 1 | Load the mailbox from the processor |
| in_data | output | 8 | Last byte the host wrote to the inbound register |
| in_full | output | 1 | Inbound byte waiting |
| out_full | output | 1 | Outbound byte not yet read by the host |
| mbox_data | output | 8 | Mailbox contents |
| busy | output | 1 | A matched host cycle is in progress |

## Verification
The bench builds the block with four register addresses that differ from one another in every nibble position, so that a miss differing only in the top nibble shows that all four address nibbles are compared. With these addresses a hostile host can also be modelled as driving an unsupported cycle type at a valid address, aborting at every state from 3 to 12, and stretching the start strobe with misleading nibbles. Strobes from the processor side are placed in the commit clock so that both same-clock priorities are exercised.

// File: rtl/lpcs_pkg.sv
package lpcs_pkg;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] CT_IO_RD  = 4'h0;
  localparam logic [3:0] CT_IO_WR  = 4'h2;
  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_TAR   = 4'hF;

  // step codes equal the cycle state number from 3 on; 1 covers start/type
  localparam logic [3:0] ST_IDLE    = 4'd0;
  localparam logic [3:0] ST_HEAD    = 4'd1;
  localparam logic [3:0] ST_ADDR_LO = 4'd6;
  localparam logic [3:0] ST_WD_LO   = 4'd7;
  localparam logic [3:0] ST_WD_HI   = 4'd8;
  localparam logic [3:0] ST_RSYNC   = 4'd9;
  localparam logic [3:0] ST_RD_LO   = 4'd10;
  localparam logic [3:0] ST_RD_HI   = 4'd11;
  localparam logic [3:0] ST_WSYNC   = 4'd11;
  localparam logic [3:0] ST_STAR    = 4'd12;
  localparam logic [3:0] ST_LAST    = 4'd13;

  typedef enum logic [1:0] {TGT_IN, TGT_OUT, TGT_STAT, TGT_MBOX} tgt_e;

  function automatic logic slave_owns(input logic [3:0] st, input logic rd);
    if (rd) return (st >= ST_RSYNC) && (st <= ST_STAR);
    return (st == ST_WSYNC) || (st == ST_STAR);
  endfunction

  function automatic logic [3:0] slave_nib(input logic [3:0] st, input logic rd,
                                           input logic [7:0] d);
    if (st == ST_STAR) return NIB_TAR;
    if (rd && st == ST_RD_LO) return d[3:0];
    if (rd && st == ST_RD_HI) return d[7:4];
    return NIB_READY;
  endfunction

  function automatic logic [7:0] status_byte(input logic inf, input logic outf);
    return {6'b0, inf, outf};
  endfunction

endpackage

// File: rtl/lpcs_decode.sv
module lpcs_decode
  import lpcs_pkg::*;
#(
  parameter logic [15:0] A_IN   = 16'h0A20,
  parameter logic [15:0] A_OUT  = 16'h0A21,
  parameter logic [15:0] A_STAT = 16'h0A22,
  parameter logic [15:0] A_MBOX = 16'h0A23
) (
  input  logic [15:0] addr,
  output logic        hit,
  output tgt_e        tgt
);
  localparam int NTGT = 4;
  localparam logic [15:0] TBL [NTGT] = '{A_IN, A_OUT, A_STAT, A_MBOX};

  logic [NTGT-1:0] match;

  for (genvar g = 0; g < NTGT; g++) begin : g_cmp
    assign match[g] = (addr == TBL[g]);
  end

  always_comb begin
    tgt = TGT_IN;
    for (int k = NTGT - 1; k >= 0; k--)
      if (match[k]) tgt = tgt_e'(2'(k));
  end

  assign hit = |match;
endmodule

// File: rtl/lpcs_seq.sv
module lpcs_seq
  import lpcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lframe_n,
  input  logic [3:0]  lad_i,
  output logic [3:0]  step,
  output logic        is_rd,
  output logic [15:0] addr_now,
  output logic        addr_done,
  output logic        commit,
  output logic        abort_evt,
  output logic [7:0]  wdata
);
  logic        start_ok;
  logic [11:0] addr_sh;
  logic        in_body;

  assign in_body   = (step > ST_HEAD);
  assign addr_now  = {addr_sh, lad_i};
  assign addr_done = (step == ST_ADDR_LO) && lframe_n;
  assign commit    = (step == ST_STAR) && lframe_n;
  assign abort_evt = in_body && !lframe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= ST_IDLE;
      start_ok <= 1'b0;
      is_rd    <= 1'b0;
      addr_sh  <= '0;
      wdata    <= '0;
    end else if (step == ST_IDLE) begin
      if (!lframe_n) begin
        step     <= ST_HEAD;
        start_ok <= (lad_i == NIB_START);
      end
    end else if (step == ST_HEAD) begin
      if (!lframe_n)
        start_ok <= (lad_i == NIB_START);
      else if (start_ok && (lad_i == CT_IO_RD || lad_i == CT_IO_WR)) begin
        is_rd <= (lad_i == CT_IO_RD);
        step  <= 4'd3;
      end else
        step <= ST_IDLE;
    end else if (!lframe_n) begin
      step <= ST_IDLE;
    end else begin
      if (step <= ST_ADDR_LO) addr_sh <= addr_now[11:0];
      if (step == ST_WD_LO) wdata[3:0] <= lad_i;
      if (step == ST_WD_HI) wdata[7:4] <= lad_i;
      step <= (step == ST_LAST) ? ST_IDLE : step + 4'd1;
    end
  end
endmodule

// File: rtl/lpcs_regs.sv
module lpcs_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_in,
  input  logic          wr_mbox,
  input  logic          rd_out,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cpu_out_data,
  input  logic          cpu_out_we,
  input  logic          cpu_in_ack,
  input  logic [DW-1:0] cpu_mbox_data,
  input  logic          cpu_mbox_we,
  output logic [DW-1:0] in_data,
  output logic          in_full,
  output logic [DW-1:0] out_data,
  output logic          out_full,
  output logic [DW-1:0] mbox_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data   <= '0;
      in_full   <= 1'b0;
      out_data  <= '0;
      out_full  <= 1'b0;
      mbox_data <= '0;
    end else begin
      if (wr_in) begin
        in_data <= wdata;
        in_full <= 1'b1;
      end else if (cpu_in_ack)
        in_full <= 1'b0;

      if (cpu_out_we) begin
        out_data <= cpu_out_data;
        out_full <= 1'b1;
      end else if (rd_out)
        out_full <= 1'b0;

      if (wr_mbox)          mbox_data <= wdata;
      else if (cpu_mbox_we) mbox_data <= cpu_mbox_data;
    end
  end
endmodule

// File: rtl/lpc_io_slave.sv
module lpc_io_slave
  import lpcs_pkg::*;
#(
  parameter logic [15:0] ADDR_IN   = 16'h0A20,
  parameter logic [15:0] ADDR_OUT  = 16'h0A21,
  parameter logic [15:0] ADDR_STAT = 16'h0A22,
  parameter logic [15:0] ADDR_MBOX = 16'h0A23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lframe_n,
  input  logic [3:0] lad_i,
  output logic [3:0] lad_o,
  output logic       lad_oe,
  input  logic [7:0] cpu_out_data,
  input  logic       cpu_out_we,
  input  logic       cpu_in_ack,
  input  logic [7:0] cpu_mbox_data,
  input  logic       cpu_mbox_we,
  output logic [7:0] in_data,
  output logic       in_full,
  output logic       out_full,
  output logic [7:0] mbox_data,
  output logic       busy
);
  localparam int DW = 8;

  logic [3:0]    step;
  logic          is_rd;
  logic [15:0]   addr_now;
  logic          addr_done, commit, abort_evt;
  logic [DW-1:0] wdata, out_data, rdata_q, rd_mux;
  logic          hit, hit_q;
  tgt_e          tgt, tgt_q;
  logic          wr_in, wr_mbox, rd_out;

  lpcs_seq u_seq (
    .clk, .rst_n, .lframe_n, .lad_i,
    .step, .is_rd, .addr_now, .addr_done, .commit, .abort_evt, .wdata
  );

  lpcs_decode #(
    .A_IN(ADDR_IN), .A_OUT(ADDR_OUT), .A_STAT(ADDR_STAT), .A_MBOX(ADDR_MBOX)
  ) u_dec (
    .addr(addr_now), .hit, .tgt
  );

  always_comb begin
    unique case (tgt)
      TGT_IN:   rd_mux = in_data;
      TGT_OUT:  rd_mux = out_data;
      TGT_STAT: rd_mux = status_byte(in_full, out_full);
      default:  rd_mux = mbox_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      tgt_q   <= TGT_IN;
      rdata_q <= '0;
      busy    <= 1'b0;
    end else if (addr_done) begin
      hit_q   <= hit;
      tgt_q   <= tgt;
      rdata_q <= rd_mux;
      busy    <= hit;
    end else if (commit || abort_evt) begin
      busy <= 1'b0;
    end
  end

  assign wr_in   = commit && hit_q && !is_rd && (tgt_q == TGT_IN);
  assign wr_mbox = commit && hit_q && !is_rd && (tgt_q == TGT_MBOX);
  assign rd_out  = commit && hit_q &&  is_rd && (tgt_q == TGT_OUT);

  lpcs_regs #(.DW(DW)) u_regs (
    .clk, .rst_n, .wr_in, .wr_mbox, .rd_out, .wdata,
    .cpu_out_data, .cpu_out_we, .cpu_in_ack, .cpu_mbox_data, .cpu_mbox_we,
    .in_data, .in_full, .out_data, .out_full, .mbox_data
  );

  assign lad_oe = hit_q && slave_owns(step, is_rd);
  assign lad_o  = lad_oe ? slave_nib(step, is_rd, rdata_q) : 4'h0;
endmodule

// File: rtl/lpcs_chk.sv
module lpcs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lad_oe,
  input logic [3:0] lad_o,
  input logic       busy,
  input logic       in_full,
  input logic [7:0] in_data,
  input logic [7:0] mbox_data,
  input logic       cpu_mbox_we,
  input logic [3:0] step,
  input logic       commit,
  input logic       abort_evt,
  input logic       wr_in
);
  // R6: the target only drives inside a matched cycle
  p_oe_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lad_oe |-> busy);

  // R6: the first driven nibble is the ready sync code
  p_first_drive_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> (lad_o == 4'h0));

  // R7: bus released after the slave turnaround
  p_release_after_tar_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd12) |=> !lad_oe);

  // R9: abort silences the target at once
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && !lad_oe));

  // R5: inbound byte moves only on a write commit
  p_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_in |=> $stable(in_data));

  // R11: write commit sets the inbound flag
  p_in_full_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in |=> in_full);

  // R8: busy ends only by commit or abort
  p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(commit) || $past(abort_evt)));

  // R12: mailbox moves only through a commit or the processor port
  p_mbox_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !cpu_mbox_we) |=> $stable(mbox_data));
endmodule

bind lpc_io_slave lpcs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lad_oe(lad_oe), .lad_o(lad_o), .busy(busy),
  .in_full(in_full), .in_data(in_data), .mbox_data(mbox_data),
  .cpu_mbox_we(cpu_mbox_we), .step(step), .commit(commit),
  .abort_evt(abort_evt), .wr_in(wr_in)
);

// File: tb/test_lpc_io_slave.sv
module test_lpc_io_slave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [15:0] A_IN   = 16'h3A58;
  localparam logic [15:0] A_OUT  = 16'h7B69;
  localparam logic [15:0] A_STAT = 16'hC0F1;
  localparam logic [15:0] A_MBOX = 16'h9E27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lframe_n = 1'b1;
  logic [3:0] lad_i = 4'hF;
  logic [3:0] lad_o;
  logic lad_oe;
  logic [7:0] cpu_out_data = 8'h00;
  logic cpu_out_we = 1'b0;
  logic cpu_in_ack = 1'b0;
  logic [7:0] cpu_mbox_data = 8'h00;
  logic cpu_mbox_we = 1'b0;
  logic [7:0] in_data, mbox_data;
  logic in_full, out_full, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpc_io_slave #(.ADDR_IN(A_IN), .ADDR_OUT(A_OUT), .ADDR_STAT(A_STAT), .ADDR_MBOX(A_MBOX))
  i_lpc_io_slave (
    .clk, .rst_n, .lframe_n, .lad_i, .lad_o, .lad_oe,
    .cpu_out_data, .cpu_out_we, .cpu_in_ack, .cpu_mbox_data, .cpu_mbox_we,
    .in_data, .in_full, .out_full, .mbox_data, .busy
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_pos = 0;
  bit m_sok, m_rd, m_busy;
  logic [15:0] m_addr;
  logic [7:0] m_wd, m_snap, m_in, m_out, m_mb;
  bit m_inf, m_outf;
  int m_sel;
  int q[$];
  bit c_in, c_mb, c_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_busy = 0; m_in = 0; m_out = 0; m_mb = 0;
      m_inf = 0; m_outf = 0; m_sel = -1; q.delete();
    end else begin
      c_in = 0; c_mb = 0; c_out = 0;
      if (m_pos == 0) begin
        if (!lframe_n) begin m_pos = 1; m_sok = (lad_i == 0); end
      end else if (m_pos == 1) begin
        if (!lframe_n) m_sok = (lad_i == 0);
        else if (m_sok && (lad_i == 0 || lad_i == 2)) begin m_rd = (lad_i == 0); m_pos = 3; end
        else m_pos = 0;
      end else if (!lframe_n) begin
        m_pos = 0; m_busy = 0; q.delete();
      end else begin
        if (m_pos <= 6) m_addr = {m_addr[11:0], lad_i};
        if (m_pos == 6) begin
          m_sel = (m_addr == A_IN) ? 0 : (m_addr == A_OUT) ? 1 :
                  (m_addr == A_STAT) ? 2 : (m_addr == A_MBOX) ? 3 : -1;
          if (m_sel >= 0) begin
            m_busy = 1;
            case (m_sel)
              0: m_snap = m_in;
              1: m_snap = m_out;
              2: m_snap = {6'b0, m_inf, m_outf};
              default: m_snap = m_mb;
            endcase
            if (m_rd) q = '{0, 0, 16, 16 + m_snap[3:0], 16 + m_snap[7:4], 31, 0};
            else      q = '{0, 0, 0, 0, 16, 31, 0};
          end
        end else if (q.size() > 0) void'(q.pop_front());
        if (m_pos == 7) m_wd[3:0] = lad_i;
        if (m_pos == 8) m_wd[7:4] = lad_i;
        if (m_pos == 12) begin
          if (m_sel == 0 && !m_rd) c_in = 1;
          if (m_sel == 3 && !m_rd) c_mb = 1;
          if (m_sel == 1 &&  m_rd) c_out = 1;
          m_busy = 0;
        end
        m_pos = (m_pos == 13) ? 0 : m_pos + 1;
      end
      if (c_in) begin m_in = m_wd; m_inf = 1; end else if (cpu_in_ack) m_inf = 0;
      if (cpu_out_we) begin m_out = cpu_out_data; m_outf = 1; end else if (c_out) m_outf = 0;
      if (c_mb) m_mb = m_wd; else if (cpu_mbox_we) m_mb = cpu_mbox_data;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      e = (q.size() > 0) ? q[0] : 0;
      chk("R6 lad_oe vs model", int'(lad_oe), e / 16);
      if (e >= 16) chk("R6 lad_o vs model", int'(lad_o), e % 16);
      chk("R8 busy vs model", int'(busy), int'(m_busy));
      chk("R5 in_data vs model", int'(in_data), int'(m_in));
      chk("R11 in_full vs model", int'(in_full), int'(m_inf));
      chk("R10 out_full vs model", int'(out_full), int'(m_outf));
      chk("R12 mbox_data vs model", int'(mbox_data), int'(m_mb));
    end
  end

  // ---------------- host model ----------------
  logic       ob_oe  [14];
  logic [3:0] ob_lad [14];
  logic       ob_busy[14];

  task automatic host_io(input logic [3:0] ct, input logic [15:0] addr, input logic [7:0] wd,
                         input int abort_at, input int poke, input int pre,
                         input logic [3:0] pre_val, input logic [3:0] start_val,
                         output logic [7:0] rd);
    logic [3:0] sq [14];
    bit cut;
    cut = 0;
    for (int s = 0; s < 14; s++) begin sq[s] = 4'hF; ob_oe[s] = 0; ob_lad[s] = 0; ob_busy[s] = 0; end
    sq[1] = start_val; sq[2] = ct;
    sq[3] = addr[15:12]; sq[4] = addr[11:8]; sq[5] = addr[7:4]; sq[6] = addr[3:0];
    if (ct == 4'h2) begin sq[7] = wd[3:0]; sq[8] = wd[7:4]; end
    for (int p = 0; p < pre; p++) begin
      @(negedge clk); lframe_n = 0; lad_i = pre_val;
    end
    for (int s = 1; s < 14; s++) begin
      if (!cut) begin
        @(negedge clk);
        if (s == abort_at) begin
          cut = 1; lframe_n = 0; lad_i = 4'hF;
          @(negedge clk);
          lframe_n = 1;
        end else begin
          lframe_n   = (s == 1) ? 1'b0 : 1'b1;
          lad_i      = sq[s];
          cpu_in_ack = (s == 12 && poke == 1);
          cpu_out_we = (s == 12 && poke == 2);
          ob_oe[s] = lad_oe; ob_lad[s] = lad_o; ob_busy[s] = busy;
        end
      end
    end
    @(negedge clk);
    lframe_n = 1; lad_i = 4'hF; cpu_in_ack = 0; cpu_out_we = 0;
    rd = {ob_lad[11], ob_lad[10]};
  endtask

  task automatic hw(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] r;
    host_io(4'h2, a, d, 0, 0, 0, 4'h0, 4'h0, r);
  endtask

  task automatic hr(input logic [15:0] a, output logic [7:0] r);
    host_io(4'h0, a, 8'h00, 0, 0, 0, 4'h0, 4'h0, r);
  endtask

  task automatic cpu_pulse(input int which);
    @(negedge clk);
    cpu_in_ack = (which == 0); cpu_out_we = (which == 1); cpu_mbox_we = (which == 2);
    @(negedge clk);
    cpu_in_ack = 0; cpu_out_we = 0; cpu_mbox_we = 0;
  endtask

  int any_oe;

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk("R1 lad_oe at reset", int'(lad_oe), 0);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 in_full at reset", int'(in_full), 0);
    chk("R1 out_full at reset", int'(out_full), 0);
    chk("R1 in_data at reset", int'(in_data), 0);
    chk("R1 mbox_data at reset", int'(mbox_data), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    hw(A_IN, 8'h5A);
    chk("R5 in_data after write", int'(in_data), 8'h5A);
    chk("R5 in_full after write", int'(in_full), 1);
    chk("R7 no drive state 9", int'(ob_oe[9]), 0);
    chk("R7 sync drive state 11", int'(ob_oe[11]), 1);
    chk("R7 sync value", int'(ob_lad[11]), 0);
    chk("R7 tar value", int'(ob_lad[12]), 4'hF);
    chk("R7 release state 13", int'(ob_oe[13]), 0);
    chk("R8 busy state 7", int'(ob_busy[7]), 1);
    chk("R8 busy state 6", int'(ob_busy[6]), 0);
    chk("R8 busy cleared", int'(busy), 0);

    hr(A_STAT, r);
    chk("R6 status byte", int'(r), 8'h02);
    chk("R6 drive state 9", int'(ob_oe[9]), 1);
    chk("R6 sync nibble", int'(ob_lad[9]), 0);
    chk("R6 no drive state 8", int'(ob_oe[8]), 0);
    chk("R6 tar nibble", int'(ob_lad[12]), 4'hF);
    chk("R6 release state 13", int'(ob_oe[13]), 0);

    hr(A_IN, r);
    chk("R6 read inbound", int'(r), 8'h5A);
    chk("R6 read leaves in_full", int'(in_full), 1);

    cpu_pulse(0);
    chk("R11 ack clears in_full", int'(in_full), 0);

    cpu_out_data = 8'hC3;
    cpu_pulse(1);
    chk("R10 out_full set", int'(out_full), 1);
    hr(A_OUT, r);
    chk("R10 read outbound", int'(r), 8'hC3);
    chk("R10 out_full cleared", int'(out_full), 0);

    hw(A_OUT, 8'h99);
    hr(A_OUT, r);
    chk("R5 write to outbound ignored", int'(r), 8'hC3);
    hw(A_STAT, 8'hFF);
    hr(A_STAT, r);
    chk("R5 write to status ignored", int'(r), 8'h00);

    hw(A_MBOX, 8'h77);
    chk("R12 host mailbox write", int'(mbox_data), 8'h77);
    cpu_mbox_data = 8'h11;
    cpu_pulse(2);
    hr(A_MBOX, r);
    chk("R12 host reads cpu mailbox", int'(r), 8'h11);

    hr(16'hBA58, r);
    any_oe = 0;
    for (int s = 1; s < 14; s++) any_oe += int'(ob_oe[s]) + int'(ob_busy[s]);
    chk("R4 miss never drives", any_oe, 0);

    host_io(4'h4, A_IN, 8'hAB, 0, 0, 0, 4'h0, 4'h0, r);
    any_oe = 0;
    for (int s = 1; s < 14; s++) any_oe += int'(ob_oe[s]);
    chk("R3 unsupported type not driven", any_oe, 0);
    chk("R3 unsupported type no write", int'(in_data), 8'h5A);
    chk("R3 unsupported type no flag", int'(in_full), 0);

    host_io(4'h2, A_IN, 8'h3C, 0, 0, 2, 4'hF, 4'h0, r);
    chk("R2 stretched start accepted", int'(in_data), 8'h3C);
    host_io(4'h2, A_IN, 8'h44, 0, 0, 2, 4'h0, 4'hF, r);
    chk("R2 last start nibble rules", int'(in_data), 8'h3C);
    cpu_pulse(0);

    for (int a = 3; a <= 12; a++) begin
      host_io(4'h2, A_IN, 8'hE1, a, 0, 0, 4'h0, 4'h0, r);
      chk($sformatf("R9 abort at %0d in_data", a), int'(in_data), 8'h3C);
      chk($sformatf("R9 abort at %0d in_full", a), int'(in_full), 0);
      chk($sformatf("R9 abort at %0d busy", a), int'(busy), 0);
      chk($sformatf("R9 abort at %0d lad_oe", a), int'(lad_oe), 0);
    end
    cpu_out_data = 8'h2E;
    cpu_pulse(1);
    host_io(4'h0, A_OUT, 8'h00, 10, 0, 0, 4'h0, 4'h0, r);
    chk("R9 aborted read keeps out_full", int'(out_full), 1);

    host_io(4'h2, A_IN, 8'h66, 0, 1, 0, 4'h0, 4'h0, r);
    chk("R11 host set beats ack", int'(in_full), 1);
    chk("R11 data with race", int'(in_data), 8'h66);
    cpu_out_data = 8'h5D;
    host_io(4'h0, A_OUT, 8'h00, 0, 2, 0, 4'h0, 4'h0, r);
    chk("R10 cpu set beats host clear", int'(out_full), 1);
    chk("R10 snapshot before race", int'(r), 8'h2E);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule